// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps track of instructions that have been issued but not yet retired. Each issued instruction takes the next slot of a circular queue, and the slot number goes back to the issue logic as the rename tag. Execution units finish in any order. Each one writes its result, an exception flag and a branch-mispredict flag into its own slot, using the tag to find it. Later instructions can read a finished result by tag before that result reaches the register file.

Only the oldest slot can change architectural state. When the oldest slot holds a finished, fault-free result, the block sends its destination register and value to the register file and frees the slot. Two conditions discard every in-flight slot at once: the oldest slot holds an exception, or it holds a branch that was mispredicted. The block then reports the PC of that slot, so the front end can restart from it.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_rdy` is 1, `alloc_tag` is 0, and `commit_vld`, `flush_vld` and `lk_hit` are 0.
- R2: Allocation grants tags in strict issue order. The first tag is 0, each accepted request (`alloc_req` while `alloc_rdy`) advances the tag by one, and the tag wraps from DEPTH-1 back to 0.
- R3: When DEPTH slots are in flight, `alloc_rdy` is 0 and a request leaves the queue unchanged.
- R4: A completion (`cmp_vld`) stores its data and flags in the slot named by `cmp_tag`. A completion whose tag names a slot that is not in flight is ignored.
- R5: One cycle after `lk_tag` is presented, `lk_hit` is 1 exactly when that slot is in flight and completed, and in that case `lk_data` is the stored result.
- R6: A completed, fault-free oldest slot retires. One cycle later `commit_vld` is 1, with that slot's destination and result. At most one slot retires per cycle, and a completed younger slot waits for every older slot to retire first.
- R7: If the oldest slot is completed with its exception flag set, it is not committed. Instead, one cycle later `flush_vld` is 1, `flush_exc` is 1 and `flush_pc` holds that slot's PC. An exception takes precedence over a mispredict flag on the same slot.
- R8: If the oldest slot is completed with only its mispredict flag set, it is not committed. Instead, one cycle later `flush_vld` is 1, `flush_exc` is 0 and `flush_pc` holds that slot's PC.
- R9: In the cycle a flush is decided, `alloc_rdy` is 0, and completions arriving in that cycle are ignored.
- R10: After a flush every slot is free. The next tag granted equals the index of the slot that caused the flush, and lookups of any tag miss until new completions arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a slot for a newly issued instruction |
| alloc_pc | input | PC_W | PC of the issuing instruction |
| alloc_dst | input | REG_W | Destination architectural register |
| alloc_rdy | output | 1 | A slot can be granted this cycle |
| alloc_tag | output | IDX_W | Tag (slot index) granted to the request |
| cmp_vld | input | 1 | Completion write strobe |
| cmp_tag | input | IDX_W | Slot being completed |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | The instruction raised an exception |
| cmp_mispred | input | 1 | The instruction is a mispredicted branch |
| lk_tag | input | IDX_W | Slot to look up for an operand read |
| lk_hit | output | 1 | Looked-up slot holds a ready result (registered) |
| lk_data | output | DATA_W | Result of the looked-up slot (registered) |
| commit_vld | output | 1 | Register file write strobe |
| commit_dst | output | REG_W | Register file write address |
| commit_data | output | DATA_W | Register file write data |
| flush_vld | output | 1 | All in-flight slots were discarded |
| flush_exc | output | 1 | The flush came from an exception rather than a mispredict |
| flush_pc | output | PC_W | PC of the slot that caused the flush |

## Verification
The bench concentrates on the points where a slip in the pointer and flag handling shows up at the ports. These are: a full queue, where a pointer without a wrap bit would treat a full queue as empty and overwrite live slots; completions in reverse order, where a design that ignores the head would commit a younger result early; and completions aimed at free slots, where a missing valid check would leave a phantom ready result that a later lookup or commit exposes. It also covers exception and mispredict flushes with a simultaneous allocation request, where a design that does not block that request would leak a slot past the flush, and it checks the tag granted straight after a flush, which shows whether the tail was pulled back to the faulting slot.

// File: rtl/retire_pkg.sv
package retire_pkg;
  // What the oldest slot does in the current cycle
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_FLUSH  = 2'd2
  } head_act_e;

  function automatic head_act_e head_decide(input logic vld, input logic done,
                                            input logic exc, input logic mis);
    if (vld && done) return (exc || mis) ? HEAD_FLUSH : HEAD_RETIRE;
    return HEAD_WAIT;
  endfunction
endpackage

// File: rtl/rq_ptrs.sv
module rq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] WRAP_M  = {1'b1, {IDX_W{1'b0}}};

  logic [PTR_W-1:0] head_q, tail_q, occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop) head_q <= head_q + 1'b1;
      if (flush)     tail_q <= head_q;
      else if (push) tail_q <= tail_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign full     = (head_q ^ tail_q) == WRAP_M;
  assign empty    = head_q == tail_q;
  assign occ      = tail_q - head_q;

  // R3
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_P);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

  // R6
  head_step_chk: assert property (@(posedge clk) disable iff (rst)
    pop |=> head_q == $past(head_q) + 1'b1);
endmodule

// File: rtl/rq_flags.sv
module rq_flags #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_we,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             retire_we,
  input  logic [IDX_W-1:0] retire_idx,
  input  logic             flush,
  input  logic             cmp_vld,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_exc,
  input  logic             cmp_mis,
  output logic             cmp_ok,
  output logic [DEPTH-1:0] vld_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] exc_o,
  output logic [DEPTH-1:0] mis_o
);
  logic [DEPTH-1:0] vld_q, done_q, exc_q, mis_q;

  assign cmp_ok = cmp_vld && vld_q[cmp_idx] && !flush;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_alloc, hit_ret, hit_cmp;
    assign hit_alloc = alloc_we  && (alloc_idx  == IDX_W'(i));
    assign hit_ret   = retire_we && (retire_idx == IDX_W'(i));
    assign hit_cmp   = cmp_ok    && (cmp_idx    == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        vld_q[i]  <= 1'b0;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end else if (hit_alloc) begin
        vld_q[i]  <= 1'b1;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end else if (hit_ret) begin
        vld_q[i]  <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (hit_cmp) begin
        done_q[i] <= 1'b1;
        exc_q[i]  <= cmp_exc;
        mis_q[i]  <= cmp_mis;
      end
    end
  end

  assign vld_o  = vld_q;
  assign done_o = done_q;
  assign exc_o  = exc_q;
  assign mis_o  = mis_q;

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> vld_q == '0);

  // R4
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q & ~vld_q) == '0);
endmodule

// File: rtl/rq_store.sv
module rq_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic              cmp_we,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic [IDX_W-1:0]  head_idx,
  output logic [PC_W-1:0]   head_pc,
  output logic [REG_W-1:0]  head_dst,
  output logic [DATA_W-1:0] head_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data
);
  logic [PC_W-1:0]   pc_mem   [DEPTH];
  logic [REG_W-1:0]  dst_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  // Issue-time fields share one write port
  always_ff @(posedge clk) begin
    if (alloc_we) begin
      pc_mem[alloc_idx]  <= alloc_pc;
      dst_mem[alloc_idx] <= alloc_dst;
    end
  end

  // Result field written by completions
  always_ff @(posedge clk) begin
    if (cmp_we) data_mem[cmp_idx] <= cmp_data;
  end

  assign head_pc   = pc_mem[head_idx];
  assign head_dst  = dst_mem[head_idx];
  assign head_data = data_mem[head_idx];
  assign lk_data   = data_mem[lk_idx];
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import retire_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [REG_W-1:0]  alloc_dst,
  output logic              alloc_rdy,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmp_vld,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic              cmp_mispred,
  input  logic [IDX_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              commit_vld,
  output logic [REG_W-1:0]  commit_dst,
  output logic [DATA_W-1:0] commit_data,
  output logic              flush_vld,
  output logic              flush_exc,
  output logic [PC_W-1:0]   flush_pc
);
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              q_full, q_empty;
  logic [DEPTH-1:0]  vld, done, exc, mis;
  logic              cmp_ok, alloc_fire, retire_now, flush_now;
  logic [PC_W-1:0]   head_pc;
  logic [REG_W-1:0]  head_dst;
  logic [DATA_W-1:0] head_data, lk_rd;
  head_act_e         act;

  assign act        = head_decide(vld[head_idx], done[head_idx], exc[head_idx], mis[head_idx]);
  assign retire_now = act == HEAD_RETIRE;
  assign flush_now  = act == HEAD_FLUSH;
  assign alloc_rdy  = !q_full && !flush_now;
  assign alloc_fire = alloc_req && alloc_rdy;
  assign alloc_tag  = tail_idx;

  rq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(alloc_fire), .pop(retire_now), .flush(flush_now),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(q_full), .empty(q_empty)
  );

  rq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_fire), .alloc_idx(tail_idx),
    .retire_we(retire_now), .retire_idx(head_idx),
    .flush(flush_now),
    .cmp_vld(cmp_vld), .cmp_idx(cmp_tag), .cmp_exc(cmp_exc), .cmp_mis(cmp_mispred),
    .cmp_ok(cmp_ok),
    .vld_o(vld), .done_o(done), .exc_o(exc), .mis_o(mis)
  );

  rq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PC_W(PC_W), .REG_W(REG_W)) u_store (
    .clk(clk),
    .alloc_we(alloc_fire), .alloc_idx(tail_idx), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
    .cmp_we(cmp_ok), .cmp_idx(cmp_tag), .cmp_data(cmp_data),
    .head_idx(head_idx), .head_pc(head_pc), .head_dst(head_dst), .head_data(head_data),
    .lk_idx(lk_tag), .lk_data(lk_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_vld  <= 1'b0;
      commit_dst  <= '0;
      commit_data <= '0;
      flush_vld   <= 1'b0;
      flush_exc   <= 1'b0;
      flush_pc    <= '0;
      lk_hit      <= 1'b0;
      lk_data     <= '0;
    end else begin
      commit_vld <= retire_now;
      flush_vld  <= flush_now;
      lk_hit     <= vld[lk_tag] && done[lk_tag];
      lk_data    <= lk_rd;
      if (retire_now) begin
        commit_dst  <= head_dst;
        commit_data <= head_data;
      end
      if (flush_now) begin
        flush_exc <= exc[head_idx];
        flush_pc  <= head_pc;
      end
    end
  end

  // R7
  exc_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!q_empty && vld[head_idx] && done[head_idx] && exc[head_idx])
      |=> (flush_vld && flush_exc && !commit_vld));
endmodule

// File: tb/retire_queue_test.sv
module retire_queue_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_req = 0, cmp_vld = 0, cmp_exc = 0, cmp_mispred = 0;
  logic [31:0] alloc_pc = 0, cmp_data = 0;
  logic [4:0]  alloc_dst = 0;
  logic [2:0]  cmp_tag = 0, lk_tag = 0;
  logic        alloc_rdy, lk_hit, commit_vld, flush_vld, flush_exc;
  logic [2:0]  alloc_tag;
  logic [31:0] lk_data, commit_data, flush_pc;
  logic [4:0]  commit_dst;

  int total = 0, bad = 0;

  retire_queue uut (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
    .alloc_rdy(alloc_rdy), .alloc_tag(alloc_tag),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .commit_vld(commit_vld), .commit_dst(commit_dst), .commit_data(commit_data),
    .flush_vld(flush_vld), .flush_exc(flush_exc), .flush_pc(flush_pc)
  );

  always #2 clk = ~clk;

  // Reference model state
  int          mh = 0, mt = 0;
  bit          mv[8], md[8], mx[8], mm[8];
  logic [31:0] mpc[8], mdata[8];
  logic [4:0]  mdst[8];
  bit          was_fl = 0;
  // Expected registered outputs
  bit          e_cv = 0, e_fv = 0, e_fx = 0, e_lh = 0;
  logic [4:0]  e_cd = 0;
  logic [31:0] e_cdata = 0, e_fpc = 0, e_ld = 0;
  string       e_llbl = "R1";

  task automatic chk(input bit ok, input string lbl, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  function automatic bit ready_of();
    int hi = mh % 8;
    bit full = ((mh ^ mt) == 8);
    bit fl = mv[hi] && md[hi] && (mx[hi] || mm[hi]);
    return !full && !fl;
  endfunction

  task automatic step(input bit a_req, input logic [31:0] a_pc, input logic [4:0] a_dst,
                      input bit c_v, input logic [2:0] c_t, input logic [31:0] c_d,
                      input bit c_x, input bit c_m, input logic [2:0] lk);
    int hi; bit full, fl, cm, rdy, cok;
    @(negedge clk);
    // Registered outputs from the previous cycle
    chk(commit_vld == e_cv, "R6 commit_vld", commit_vld, e_cv);
    if (e_cv) begin
      chk(commit_dst == e_cd, "R6 commit_dst", commit_dst, e_cd);
      chk(commit_data == e_cdata, "R6 commit_data", commit_data, e_cdata);
    end
    chk(flush_vld == e_fv, e_fx ? "R7 flush_vld" : "R8 flush_vld", flush_vld, e_fv);
    if (e_fv) begin
      chk(flush_exc == e_fx, e_fx ? "R7 flush_exc" : "R8 flush_exc", flush_exc, e_fx);
      chk(flush_pc == e_fpc, e_fx ? "R7 flush_pc" : "R8 flush_pc", flush_pc, e_fpc);
    end
    chk(lk_hit == e_lh, {e_llbl, " lk_hit"}, lk_hit, e_lh);
    if (e_lh) chk(lk_data == e_ld, "R4 lk_data", lk_data, e_ld);
    // Drive this cycle
    alloc_req = a_req; alloc_pc = a_pc; alloc_dst = a_dst;
    cmp_vld = c_v; cmp_tag = c_t; cmp_data = c_d; cmp_exc = c_x; cmp_mispred = c_m;
    lk_tag = lk;
    hi   = mh % 8;
    full = ((mh ^ mt) == 8);
    fl   = mv[hi] && md[hi] && (mx[hi] || mm[hi]);
    cm   = mv[hi] && md[hi] && !fl;
    rdy  = !full && !fl;
    #0;
    chk(alloc_rdy == rdy, fl ? "R9 alloc_rdy" : (full ? "R3 alloc_rdy" : "R2 alloc_rdy"), alloc_rdy, rdy);
    chk(alloc_tag == 3'(mt % 8), was_fl ? "R10 alloc_tag" : "R2 alloc_tag", alloc_tag, mt % 8);
    // Model update
    e_lh = mv[lk] && md[lk]; e_ld = mdata[lk];
    e_llbl = was_fl ? "R10" : "R5";
    e_cv = cm; e_cd = mdst[hi]; e_cdata = mdata[hi];
    e_fv = fl; e_fx = mx[hi]; e_fpc = mpc[hi];
    cok = c_v && mv[c_t] && !fl;
    if (cok) begin md[c_t] = 1; mx[c_t] = c_x; mm[c_t] = c_m; mdata[c_t] = c_d; end
    if (cm) begin mv[hi] = 0; md[hi] = 0; mh = (mh + 1) % 16; end
    if (fl) begin
      for (int i = 0; i < 8; i++) begin mv[i] = 0; md[i] = 0; mx[i] = 0; mm[i] = 0; end
      mt = mh;
    end
    if (a_req && rdy) begin
      mv[mt % 8] = 1; md[mt % 8] = 0; mx[mt % 8] = 0; mm[mt % 8] = 0;
      mpc[mt % 8] = a_pc; mdst[mt % 8] = a_dst;
      mt = (mt + 1) % 16;
    end
    was_fl = fl;
  endtask

  task automatic idle(input logic [2:0] lk);
    step(0, 0, 0, 0, 0, 0, 0, 0, lk);
  endtask

  task automatic finish_run();
    idle(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin mpc[i] = 0; mdata[i] = 0; mdst[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(alloc_rdy == 1, "R1 alloc_rdy", alloc_rdy, 1);
    chk(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);
    chk(commit_vld == 0, "R1 commit_vld", commit_vld, 0);
    chk(flush_vld == 0, "R1 flush_vld", flush_vld, 0);
    chk(lk_hit == 0, "R1 lk_hit", lk_hit, 0);

    // R3: fill past capacity; the ninth request must be refused
    for (int i = 0; i < 10; i++) step(1, 32'h100 + i*4, 5'(i + 1), 0, 0, 0, 0, 0, 0);
    // R6: complete out of order; nothing retires until slot 0 completes
    step(0, 0, 0, 1, 3'd2, 32'hA2, 0, 0, 3'd2);
    step(0, 0, 0, 1, 3'd1, 32'hA1, 0, 0, 3'd2);
    idle(3'd1);
    step(0, 0, 0, 1, 3'd0, 32'hA0, 0, 0, 3'd0);
    repeat (4) idle(3'd2);
    // R7 and R9: exception at slot 3 while a request is pending
    step(0, 0, 0, 1, 3'd4, 32'hB4, 0, 0, 3'd4);
    step(0, 0, 0, 1, 3'd3, 32'hB3, 1, 1, 3'd4);
    step(1, 32'h900, 5'd9, 1, 3'd5, 32'hB5, 0, 0, 3'd4);
    // R10: slot 4 was completed before the flush; the lookup must now miss
    step(1, 32'h904, 5'd10, 0, 0, 0, 0, 0, 3'd4);
    // R4: completion aimed at a free slot has no effect
    step(0, 0, 0, 1, 3'd6, 32'hDEAD, 0, 0, 3'd6);
    idle(3'd6);
    // R8: mispredict at the head
    step(0, 0, 0, 1, 3'd3, 32'hC3, 0, 1, 3'd3);
    idle(3'd3);
    idle(3'd3);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit a, cv, cx, cmis; logic [2:0] ct, lk; int start;
      a    = ($urandom % 10) < 6;
      cv   = ($urandom % 10) < 6;
      cx   = ($urandom % 24) == 0;
      cmis = ($urandom % 24) == 0;
      ct   = 3'($urandom);
      if (($urandom % 10) < 7) begin
        start = $urandom % 8;
        for (int k = 0; k < 8; k++) begin
          if (mv[(start + k) % 8] && !md[(start + k) % 8]) begin
            ct = 3'((start + k) % 8);
            break;
          end
        end
      end
      lk = 3'($urandom);
      step(a, $urandom, 5'($urandom), cv, ct, $urandom, cx, cmis, lk);
    end
    finish_run();
  end
endmodule